// File: doc/BRIEF.md
# Fused-Idiom Integer ALU Slice

This block is a 64-bit execution slice that evaluates, in a single operation, the combined effect of a pair of adjacent integer instructions that an upstream decoder has merged. Each operation code names one two-step idiom, for example a right shift followed by an add, or a 32-bit add followed by a halfword sign extension. The slice produces exactly the value that the second instruction of the pair would leave in its destination register.

Two 64-bit operands and a 5-bit operation code arrive together with a valid strobe. The result is computed combinationally by three small sub-units: shift and extract, word add and extend, and logic then extract. One of them is selected, and the result is captured in an output register. The output register loads only on valid cycles. The output valid flag is the input strobe delayed by one clock. Operation codes that name no idiom produce a zero result.

Top module: `fuse_alu`

## Requirements
- R1: Codes 1, 2 and 3 return src1[31:0], zero-extended to 64 bits and then shifted left by 1, 2 and 3 respectively.
- R2: Code 4 returns src1[15:8] zero-extended to 64 bits.
- R3: Code 5 returns (src1 << 4) + src2 modulo 2^64.
- R4: Codes 6, 7, 8 and 9 return (src1 logically shifted right by 29, 30, 31 and 32 respectively) + src2 modulo 2^64.
- R5: Code 10 returns (src1 & 1) + src2 as a 64-bit sum. Code 11 returns the 32-bit sum (src1 & 1) + src2[31:0], sign-extended from its bit 31.
- R6: Code 12 returns {src1[63:8], 8'h00} | src2.
- R7: Codes 13 to 16 first form w = src1[31:0] + src2[31:0] (32 bits). They return, in code order: w[7:0] zero-extended, w[0] alone, w[15:0] zero-extended, and w[15:0] sign-extended from bit 15.
- R8: Codes 24 to 31 (bits 4..3 = 11) first form L from op bits 1..0: 00 gives src1 & src2, 01 gives src1 | src2, 10 gives src1 ^ src2, and 11 gives src1 with each nonzero byte set to 0xFF and each zero byte set to 0x00 (src2 is not used). When op bit 2 is 0 the result is L[0] alone. When op bit 2 is 1 the result is L[15:0] zero-extended.
- R9: Codes 0 and 17 to 23 return a zero result.
- R10: The result for inputs presented with in_valid high appears on out_result one clock later, and out_valid equals in_valid delayed by one clock.
- R11: While in_valid is low, out_result keeps its value whatever the operands and code do.
- R12: A synchronous active-high reset clears out_valid and out_result to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and code are valid this cycle |
| op_sel | input | 5 | Fused operation code |
| src1 | input | 64 | First operand |
| src2 | input | 64 | Second operand |
| out_valid | output | 1 | Result register holds a new result |
| out_result | output | 64 | Registered result |

## Verification
Every result is due exactly one rising edge after the cycle in which in_valid is high. The reset clear and the hold behaviour are due on that same single edge. The bench changes inputs on the falling edge, lets one rising edge capture them, and reads out_result and out_valid on the following falling edge, so each check lands one edge after its stimulus. Expected values come from a model that executes the two original instructions one after the other on random operands and on the corner values all ones, 0x8000_0000, 0xFFFF_7FFF and a word with bit 31 set and bit 15 clear.

// File: rtl/fuse_alu_pkg.sv
package fuse_alu_pkg;

    localparam int XLEN_DEF = 64;
    localparam int OP_W     = 5;

    // Operation codes; the logic family packs its sub-select into bits 2..0.
    typedef enum logic [OP_W-1:0] {
        FOP_NONE      = 5'd0,
        FOP_ZWSL1     = 5'd1,
        FOP_ZWSL2     = 5'd2,
        FOP_ZWSL3     = 5'd3,
        FOP_BYTE1     = 5'd4,
        FOP_SL4ADD    = 5'd5,
        FOP_SR29ADD   = 5'd6,
        FOP_SR30ADD   = 5'd7,
        FOP_SR31ADD   = 5'd8,
        FOP_SR32ADD   = 5'd9,
        FOP_ODDADD    = 5'd10,
        FOP_ODDADDW   = 5'd11,
        FOP_HIMASKOR  = 5'd12,
        FOP_WADD_B8   = 5'd13,
        FOP_WADD_B1   = 5'd14,
        FOP_WADD_ZH   = 5'd15,
        FOP_WADD_SH   = 5'd16,
        FOP_LG_AND_B1 = 5'd24,
        FOP_LG_OR_B1  = 5'd25,
        FOP_LG_XOR_B1 = 5'd26,
        FOP_LG_ORC_B1 = 5'd27,
        FOP_LG_AND_ZH = 5'd28,
        FOP_LG_OR_ZH  = 5'd29,
        FOP_LG_XOR_ZH = 5'd30,
        FOP_LG_ORC_ZH = 5'd31
    } fop_e;

    typedef enum logic [1:0] {
        LSEL_AND = 2'b00,
        LSEL_OR  = 2'b01,
        LSEL_XOR = 2'b10,
        LSEL_ORC = 2'b11
    } lsel_e;

    // Prefix of the logic-then-extract family in the code space.
    localparam logic [1:0] LOGIC_PREFIX = 2'b11;

    // First right-shift amount of the shift-right-add lanes and lane count.
    localparam int SRA_BASE  = 29;
    localparam int SRA_LANES = 4;

    // Per-unit answer: whether the unit owns the code, and its value.
    typedef struct packed {
        logic                hit;
        logic [XLEN_DEF-1:0] value;
    } unit_res_t;

endpackage

// File: rtl/fuse_shift_unit.sv
module fuse_shift_unit
    import fuse_alu_pkg::*;
#(
    parameter int XLEN = XLEN_DEF
) (
    input  fop_e            op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic            hit,
    output logic [XLEN-1:0] value
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] zw;
    logic [XLEN-1:0] sr_sum [SRA_LANES];
    logic [XLEN-1:0] sl4_sum;

    assign zw      = {{HALF{1'b0}}, a[HALF-1:0]};
    assign sl4_sum = (a << 4) + b;

    // One adder per right-shift lane; shifts are fixed wiring.
    for (genvar k = 0; k < SRA_LANES; k++) begin : g_sr_lane
        assign sr_sum[k] = (a >> (SRA_BASE + k)) + b;
    end

    always_comb begin
        hit   = 1'b1;
        value = '0;
        unique case (op)
            FOP_ZWSL1:   value = zw << 1;
            FOP_ZWSL2:   value = zw << 2;
            FOP_ZWSL3:   value = zw << 3;
            FOP_BYTE1:   value = {{(XLEN-8){1'b0}}, a[15:8]};
            FOP_SL4ADD:  value = sl4_sum;
            FOP_SR29ADD: value = sr_sum[0];
            FOP_SR30ADD: value = sr_sum[1];
            FOP_SR31ADD: value = sr_sum[2];
            FOP_SR32ADD: value = sr_sum[3];
            default:     hit   = 1'b0;
        endcase
    end
endmodule

// File: rtl/fuse_addw_unit.sv
module fuse_addw_unit
    import fuse_alu_pkg::*;
#(
    parameter int XLEN = XLEN_DEF
) (
    input  fop_e            op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic            hit,
    output logic [XLEN-1:0] value
);
    localparam int HALF = XLEN / 2;

    logic [HALF-1:0] wsum;
    logic [HALF-1:0] odd_w;
    logic [XLEN-1:0] odd_x;
    logic [XLEN-1:0] him;

    assign wsum  = a[HALF-1:0] + b[HALF-1:0];
    assign odd_w = {{(HALF-1){1'b0}}, a[0]} + b[HALF-1:0];
    assign odd_x = {{(XLEN-1){1'b0}}, a[0]} + b;
    assign him   = {a[XLEN-1:8], 8'h00} | b;

    always_comb begin
        hit   = 1'b1;
        value = '0;
        unique case (op)
            FOP_ODDADD:   value = odd_x;
            FOP_ODDADDW:  value = {{HALF{odd_w[HALF-1]}}, odd_w};
            FOP_HIMASKOR: value = him;
            FOP_WADD_B8:  value = {{(XLEN-8){1'b0}}, wsum[7:0]};
            FOP_WADD_B1:  value = {{(XLEN-1){1'b0}}, wsum[0]};
            FOP_WADD_ZH:  value = {{(XLEN-16){1'b0}}, wsum[15:0]};
            FOP_WADD_SH:  value = {{(XLEN-16){wsum[15]}}, wsum[15:0]};
            default:      hit   = 1'b0;
        endcase
    end
endmodule

// File: rtl/fuse_logic_unit.sv
module fuse_logic_unit
    import fuse_alu_pkg::*;
#(
    parameter int XLEN = XLEN_DEF
) (
    input  logic [OP_W-1:0] op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic            hit,
    output logic [XLEN-1:0] value
);
    localparam int NBYTES = XLEN / 8;

    lsel_e           lsel;
    logic            wide;
    logic [XLEN-1:0] orc;
    logic [XLEN-1:0] lres;

    assign lsel = lsel_e'(op[1:0]);
    assign wide = op[2];
    assign hit  = (op[OP_W-1:OP_W-2] == LOGIC_PREFIX);

    for (genvar g = 0; g < NBYTES; g++) begin : g_orc
        assign orc[g*8 +: 8] = (|a[g*8 +: 8]) ? 8'hFF : 8'h00;
    end

    always_comb begin
        unique case (lsel)
            LSEL_AND: lres = a & b;
            LSEL_OR:  lres = a | b;
            LSEL_XOR: lres = a ^ b;
            default:  lres = orc;
        endcase
    end

    always_comb begin
        if (!hit)
            value = '0;
        else if (wide)
            value = {{(XLEN-16){1'b0}}, lres[15:0]};
        else
            value = {{(XLEN-1){1'b0}}, lres[0]};
    end
endmodule

// File: rtl/fuse_alu.sv
module fuse_alu
    import fuse_alu_pkg::*;
#(
    parameter int XLEN = XLEN_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [4:0]      op_sel,
    input  logic [XLEN-1:0] src1,
    input  logic [XLEN-1:0] src2,
    output logic            out_valid,
    output logic [XLEN-1:0] out_result
);
    localparam int NUNITS = 3;

    fop_e            op;
    logic [NUNITS-1:0] hits;
    logic [XLEN-1:0] vals [NUNITS];
    logic [XLEN-1:0] comb_res;
    logic            v_q;
    logic [XLEN-1:0] r_q;

    assign op = fop_e'(op_sel);

    fuse_shift_unit #(.XLEN(XLEN)) u_shift (
        .op(op), .a(src1), .b(src2), .hit(hits[0]), .value(vals[0])
    );

    fuse_addw_unit #(.XLEN(XLEN)) u_addw (
        .op(op), .a(src1), .b(src2), .hit(hits[1]), .value(vals[1])
    );

    fuse_logic_unit #(.XLEN(XLEN)) u_logic (
        .op(op_sel), .a(src1), .b(src2), .hit(hits[2]), .value(vals[2])
    );

    // Units own disjoint code ranges, so a gated OR merges them.
    always_comb begin
        comb_res = '0;
        for (int u = 0; u < NUNITS; u++) begin
            if (hits[u])
                comb_res = comb_res | vals[u];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q <= 1'b0;
            r_q <= '0;
        end else begin
            v_q <= in_valid;
            if (in_valid)
                r_q <= comb_res;
        end
    end

    assign out_valid  = v_q;
    assign out_result = r_q;
endmodule

// File: rtl/fuse_alu_chk.sv
module fuse_alu_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic [4:0]      op_sel,
    input logic [XLEN-1:0] src1,
    input logic [XLEN-1:0] src2,
    input logic            out_valid,
    input logic [XLEN-1:0] out_result
);
    assert_reset_clear_R12: assert property (@(posedge clk)
        rst |=> (!out_valid && out_result == '0));

    assert_valid_follow_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_valid_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_result));

    assert_zwsl_range_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel >= 5'd1 && op_sel <= 5'd3)
        |=> (out_result[XLEN-1:35] == '0 && out_result[0] == 1'b0));

    assert_byte_range_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 5'd4) |=> (out_result[XLEN-1:8] == '0));

    assert_himask_low_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 5'd12) |=> (out_result[7:0] == $past(src2[7:0])));

    assert_wadd_bit_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 5'd14) |=> (out_result[XLEN-1:1] == '0));

    assert_logic_bit_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel[4:2] == 3'b110) |=> (out_result[XLEN-1:1] == '0));

    assert_logic_half_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel[4:2] == 3'b111) |=> (out_result[XLEN-1:16] == '0));

    assert_undef_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op_sel == 5'd0 || (op_sel >= 5'd17 && op_sel <= 5'd23)))
        |=> (out_result == '0));
endmodule

bind fuse_alu fuse_alu_chk #(.XLEN(XLEN)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
    .src1(src1), .src2(src2), .out_valid(out_valid), .out_result(out_result)
);

// File: tb/sim_fuse_alu.sv
`timescale 1ns/1ps
module sim_fuse_alu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [4:0]  op_sel = 5'd0;
    logic [63:0] src1 = '0;
    logic [63:0] src2 = '0;
    logic        out_valid;
    logic [63:0] out_result;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    fuse_alu u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
        .src1(src1), .src2(src2), .out_valid(out_valid), .out_result(out_result)
    );

    function automatic logic [63:0] sx32(input logic [31:0] w);
        return {{32{w[31]}}, w};
    endfunction

    // Runs the two original instructions one after the other.
    function automatic logic [63:0] model(input logic [4:0] op, input logic [63:0] a, input logic [63:0] b);
        logic [63:0] t;
        logic [63:0] l;
        case (op)
            5'd1, 5'd2, 5'd3: begin t = a << 32; return t >> (32 - op); end
            5'd4:  begin t = a >> 8; return t & 64'd255; end
            5'd5:  begin t = a << 4; return t + b; end
            5'd6, 5'd7, 5'd8, 5'd9: begin t = a >> (op + 23); return t + b; end
            5'd10: begin t = a & 64'd1; return t + b; end
            5'd11: begin t = a & 64'd1; return sx32(t[31:0] + b[31:0]); end
            5'd12: begin t = a & 64'hFFFF_FFFF_FFFF_FF00; return t | b; end
            5'd13, 5'd14, 5'd15, 5'd16: begin
                t = sx32(a[31:0] + b[31:0]);
                if (op == 5'd13) return t & 64'hFF;
                if (op == 5'd14) return t & 64'h1;
                if (op == 5'd15) return t & 64'hFFFF;
                return {{48{t[15]}}, t[15:0]};
            end
            default: begin
                if (op[4:3] != 2'b11) return 64'd0;
                case (op[1:0])
                    2'b00: l = a & b;
                    2'b01: l = a | b;
                    2'b10: l = a ^ b;
                    default: for (int i = 0; i < 8; i++) l[i*8 +: 8] = (a[i*8 +: 8] != 8'h00) ? 8'hFF : 8'h00;
                endcase
                return op[2] ? (l & 64'hFFFF) : (l & 64'h1);
            end
        endcase
    endfunction

    function automatic logic [63:0] pick(input int i);
        case (i)
            0: return 64'hFFFF_FFFF_FFFF_FFFF;
            1: return 64'h0000_0000_8000_0000;
            2: return 64'h0000_0000_FFFF_7FFF;
            3: return 64'h1234_5678_8000_7123;
            4: return 64'h0;
            default: return {$urandom, $urandom};
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // Presents one operation and checks its result one edge later.
    task automatic run_op(input string tag, input logic [4:0] op, input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        in_valid = 1'b1; op_sel = op; src1 = a; src2 = b;
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, out_result, model(op, a, b));
        check({tag, " valid R10"}, {63'd0, out_valid}, 64'd1);
    endtask

    task automatic sweep(input string tag, input logic [4:0] lo, input logic [4:0] hi);
        for (int op = lo; op <= hi; op++)
            for (int i = 0; i < 8; i++)
                run_op(tag, 5'(op), pick(i), pick((i * 3 + 2) % 8));
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R12 reset valid", {63'd0, out_valid}, 64'd0);
        check("R12 reset result", out_result, 64'd0);
    endtask

    task automatic t_zwsl;   sweep("R1", 5'd1, 5'd3);   endtask
    task automatic t_byte;   sweep("R2", 5'd4, 5'd4);   endtask
    task automatic t_sl4;    sweep("R3", 5'd5, 5'd5);   endtask
    task automatic t_sradd;  sweep("R4", 5'd6, 5'd9);   endtask
    task automatic t_odd;    sweep("R5", 5'd10, 5'd11); endtask
    task automatic t_himask; sweep("R6", 5'd12, 5'd12); endtask
    task automatic t_wadd;   sweep("R7", 5'd13, 5'd16); endtask
    task automatic t_logic;  sweep("R8", 5'd24, 5'd31); endtask

    task automatic t_undef;
        run_op("R9", 5'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);
        for (int op = 17; op <= 23; op++)
            run_op("R9", 5'(op), pick(op % 5), 64'hFFFF_FFFF_FFFF_FFFF);
    endtask

    task automatic t_hold;
        logic [63:0] ref_v;
        run_op("R11 setup", 5'd5, 64'h0123_4567_89AB_CDEF, 64'h1111);
        ref_v = model(5'd5, 64'h0123_4567_89AB_CDEF, 64'h1111);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            op_sel = 5'(i + 10); src1 = pick(i); src2 = pick(i + 5);
            @(negedge clk);
            check("R11 hold", out_result, ref_v);
            check("R10 idle valid", {63'd0, out_valid}, 64'd0);
        end
    endtask

    task automatic t_reset_mid;
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1; op_sel = 5'd12; src1 = pick(0); src2 = pick(0);
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        check("R12 mid valid", {63'd0, out_valid}, 64'd0);
        check("R12 mid result", out_result, 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_zwsl();
        t_byte();
        t_sl4();
        t_sradd();
        t_odd();
        t_himask();
        t_wadd();
        t_logic();
        t_undef();
        t_hold();
        t_reset_mid();
        run_op("R10 after reset", 5'd16, 64'h0000_0000_0000_7FFF, 64'h1);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule